// File: doc/BRIEF.md
# Interconnect idle handshake controller

This block takes one power domain off the on-chip interconnect and puts it back on. Software writes a masked control word to request a disconnect or a connect. On a disconnect the controller raises an idle request toward the interconnect. It waits for the interconnect to acknowledge, then waits for the interconnect to report the domain idle, then holds the domain idle for a programmable minimum time. On a connect it withdraws the idle request and waits for the acknowledge to fall.

Each waiting phase has its own window, counted in ticks of a prescaled enable. The prescaler restarts whenever the controller enters a phase. If the acknowledge or the idle indication does not come within its window, the controller withdraws the request, falls back to Connected and raises a sticky error bit.

The controller has six states:
- Connected: stable.
- Request: waiting for the acknowledge.
- Drain: waiting for the idle indication.
- Hold: minimum idle time.
- Idle: stable.
- Release: waiting for the acknowledge to fall.

Its transitions are:
- Connected→Request on an accepted disconnect.
- Request→Drain when the acknowledge arrives.
- Drain→Hold when the idle indication arrives.
- Hold→Idle when the hold expires.
- Idle→Release on an accepted connect.
- Release→Connected when the acknowledge falls.
- Request, Drain or Release→Connected with the error bit set when their window expires.

Top module: `ic_idle_ctrl`

## Requirements
- R1: After reset `idle_req` is low, the status word (select 2) reads 0x8 (bit 3 = connected), and the timing word (select 1) reads 0x00081010. The idle bit and the connected bit are never both set.
- R2: The timing word holds the acknowledge window A at bits [4:0], the idle window I at bits [12:8] and the hold time H at bits [21:16]. Every other bit reads 0.
- R3: In the control word (select 0), bit 2 requests a disconnect, bit 3 requests a connect and bit 0 clears the error. Each acts only when the bit 16 places higher is set in the same write. Control writes do not persist as state.
- R4: An accepted disconnect in Connected raises `idle_req` after that clock edge. The status word reads 0x0 while the controller waits for the acknowledge or the idle indication. It reads 0x4 (bit 2 = idle) from the cycle after the idle indication is sampled.
- R5: One tick occurs every TICK_DIV cycles, counted from phase entry. `idle_req` stays high for at most (A+1)*TICK_DIV cycles waiting for the acknowledge. An acknowledge sampled in the last cycle of the window still advances to Drain. On expiry `idle_req` falls and the status word reads 0x9.
- R6: After the acknowledge, the controller waits at most (I+1)*TICK_DIV cycles for the idle indication. On expiry `idle_req` falls and the status word reads 0x9.
- R7: Hold lasts exactly (H+1)*TICK_DIV cycles, and connect requests during Hold are ignored. With a connect written every cycle, `idle_req` stays high for (H+1)*TICK_DIV+1 cycles after the idle indication is sampled.
- R8: An accepted connect in Idle drops `idle_req` after that edge, and the status word reads 0x0. When the acknowledge falls, the status word reads 0x8. If the acknowledge stays high for (A+1)*TICK_DIV cycles, the status word reads 0x9.
- R9: A disconnect is accepted only in Connected and a connect only in Idle. A request written in any other state is dropped, not queued.
- R10: The error bit (status bit 0) stays set until a control write with bits 0 and 16 both set. A write of bit 0 alone leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 control, 1 timing, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| idle_ack | input | 1 | Idle acknowledge from the interconnect |
| idle_ind | input | 1 | Idle indication from the interconnect |
| idle_req | output | 1 | Idle request to the interconnect |

## Verification
The acknowledge window is swept over all 32 values with the acknowledge withheld, so the measured width of `idle_req` separates an off-by-one in the window from an off-by-one in the prescaler. The idle window is swept the same way with the acknowledge given at once, which separates the Drain limit from the Request limit. The hold time is swept over all 64 values with a connect written every cycle, which shows both the hold length and that connects are dropped during Hold. Single runs place the acknowledge in the last cycle of its window and one cycle after it. Other single runs send writes whose masks are missing or point at the wrong bit, and requests in states that do not accept them.

// File: rtl/ic_idle_pkg.sv
package ic_idle_pkg;

    typedef enum logic [2:0] {
        S_CONN  = 3'd0,
        S_REQ   = 3'd1,
        S_DRAIN = 3'd2,
        S_HOLD  = 3'd3,
        S_IDLE  = 3'd4,
        S_EXIT  = 3'd5
    } hs_state_e;

    // register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_TIME = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    // control word bit positions
    localparam int CTL_CLR_BIT = 0;
    localparam int CTL_DIS_BIT = 2;
    localparam int CTL_CON_BIT = 3;
    localparam int CTL_WE_OFS  = 16;

    // timing word field positions
    localparam int TM_ACK_LSB  = 0;
    localparam int TM_IDLE_LSB = 8;
    localparam int TM_HOLD_LSB = 16;

    // status word bit positions
    localparam int ST_ERR_BIT  = 0;
    localparam int ST_IDLE_BIT = 2;
    localparam int ST_CONN_BIT = 3;

endpackage

// File: rtl/ic_idle_timer.sv
module ic_idle_timer #(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    generate
        if (TICK_DIV <= 1) begin : g_no_presc
            assign tick = 1'b1;
        end else begin : g_presc
            logic [PW-1:0] presc_q;
            assign tick = (presc_q == PW'(TICK_DIV - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       presc_q <= '0;
                else if (restart) presc_q <= '0;
                else if (tick)    presc_q <= '0;
                else              presc_q <= presc_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

    assign expire = tick && (cnt_q == limit);

endmodule

// File: rtl/ic_idle_regs.sv
module ic_idle_regs
    import ic_idle_pkg::*;
#(
    parameter int               ACK_W    = 5,
    parameter int               IDLE_W   = 5,
    parameter int               HOLD_W   = 6,
    parameter logic [ACK_W-1:0]  ACK_RST  = 5'd16,
    parameter logic [IDLE_W-1:0] IDLE_RST = 5'd16,
    parameter logic [HOLD_W-1:0] HOLD_RST = 6'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [ACK_W-1:0]  ack_lim,
    output logic [IDLE_W-1:0] idle_lim,
    output logic [HOLD_W-1:0] hold_lim,
    output logic              dis_req,
    output logic              con_req,
    input  logic              err_set,
    input  logic              st_idle,
    input  logic              st_conn
);
    logic ctrl_wr, time_wr, clr_req, err_q;
    logic unused_wbits;

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    assign time_wr = reg_wr && (reg_sel == SEL_TIME);

    // a control bit acts only with its enable 16 places higher
    assign dis_req = ctrl_wr && reg_wdata[CTL_DIS_BIT] && reg_wdata[CTL_DIS_BIT + CTL_WE_OFS];
    assign con_req = ctrl_wr && reg_wdata[CTL_CON_BIT] && reg_wdata[CTL_CON_BIT + CTL_WE_OFS];
    assign clr_req = ctrl_wr && reg_wdata[CTL_CLR_BIT] && reg_wdata[CTL_CLR_BIT + CTL_WE_OFS];

    assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[15:13], reg_wdata[7:5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_lim  <= ACK_RST;
            idle_lim <= IDLE_RST;
            hold_lim <= HOLD_RST;
        end else if (time_wr) begin
            ack_lim  <= reg_wdata[TM_ACK_LSB  +: ACK_W];
            idle_lim <= reg_wdata[TM_IDLE_LSB +: IDLE_W];
            hold_lim <= reg_wdata[TM_HOLD_LSB +: HOLD_W];
        end
    end

    // sticky error: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (clr_req) err_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_TIME: begin
                reg_rdata[TM_ACK_LSB  +: ACK_W]  = ack_lim;
                reg_rdata[TM_IDLE_LSB +: IDLE_W] = idle_lim;
                reg_rdata[TM_HOLD_LSB +: HOLD_W] = hold_lim;
            end
            SEL_STAT: begin
                reg_rdata[ST_ERR_BIT]  = err_q;
                reg_rdata[ST_IDLE_BIT] = st_idle;
                reg_rdata[ST_CONN_BIT] = st_conn;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R5: a window expiry shows in the error bit on the next cycle
    p_err_raised_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_q);

    // R10: the error bit only falls on a masked clear
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_req) |=> err_q);

endmodule

// File: rtl/ic_idle_fsm.sv
module ic_idle_fsm
    import ic_idle_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis_req,
    input  logic             con_req,
    input  logic             idle_ack,
    input  logic             idle_ind,
    input  logic             expire,
    input  logic [CNT_W-1:0] ack_lim,
    input  logic [CNT_W-1:0] idle_lim,
    input  logic [CNT_W-1:0] hold_lim,
    output logic [CNT_W-1:0] tmr_limit,
    output logic             restart,
    output logic             err_set,
    output logic             idle_req,
    output logic             st_idle,
    output logic             st_conn
);
    hs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CONN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        unique case (state_q)
            S_CONN:  if (dis_req) state_d = S_REQ;
            S_REQ: begin
                if (idle_ack)    state_d = S_DRAIN;
                else if (expire) begin state_d = S_CONN; err_set = 1'b1; end
            end
            S_DRAIN: begin
                if (idle_ind)    state_d = S_HOLD;
                else if (expire) begin state_d = S_CONN; err_set = 1'b1; end
            end
            S_HOLD:  if (expire) state_d = S_IDLE;
            S_IDLE:  if (con_req) state_d = S_EXIT;
            S_EXIT: begin
                if (!idle_ack)   state_d = S_CONN;
                else if (expire) begin state_d = S_CONN; err_set = 1'b1; end
            end
            default: state_d = S_CONN;
        endcase
    end

    assign restart = (state_d != state_q);

    always_comb begin
        case (state_q)
            S_DRAIN: tmr_limit = idle_lim;
            S_HOLD:  tmr_limit = hold_lim;
            default: tmr_limit = ack_lim;
        endcase
    end

    always_comb begin
        idle_req = 1'b0;
        st_idle  = 1'b0;
        st_conn  = 1'b0;
        unique case (state_q)
            S_CONN:  st_conn  = 1'b1;
            S_REQ,
            S_DRAIN: idle_req = 1'b1;
            S_HOLD,
            S_IDLE:  begin idle_req = 1'b1; st_idle = 1'b1; end
            S_EXIT:  idle_req = 1'b0;
            default: idle_req = 1'b0;
        endcase
    end

    // R1: idle and connected are never reported together
    p_status_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_idle, st_conn}));

    // R9: while waiting for the acknowledge, requests do not move the FSM
    p_req_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REQ && !idle_ack && !expire) |=> (state_q == S_REQ));

    // R7: Hold only leads to Idle
    p_hold_no_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> (state_q == S_HOLD || state_q == S_IDLE));

    // R8: an accepted connect withdraws the idle request
    p_conn_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && con_req) |=> !idle_req);

endmodule

// File: rtl/ic_idle_ctrl.sv
module ic_idle_ctrl
    import ic_idle_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int ACK_W    = 5,
    parameter int IDLE_W   = 5,
    parameter int HOLD_W   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        idle_ack,
    input  logic        idle_ind,
    output logic        idle_req
);
    localparam int CNT_W0 = (ACK_W > IDLE_W) ? ACK_W : IDLE_W;
    localparam int CNT_W  = (CNT_W0 > HOLD_W) ? CNT_W0 : HOLD_W;

    logic [ACK_W-1:0]  ack_lim;
    logic [IDLE_W-1:0] idle_lim;
    logic [HOLD_W-1:0] hold_lim;
    logic [CNT_W-1:0]  tmr_limit;
    logic dis_req, con_req, err_set, st_idle, st_conn, restart, expire;

    ic_idle_regs #(
        .ACK_W (ACK_W),
        .IDLE_W(IDLE_W),
        .HOLD_W(HOLD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ack_lim  (ack_lim),
        .idle_lim (idle_lim),
        .hold_lim (hold_lim),
        .dis_req  (dis_req),
        .con_req  (con_req),
        .err_set  (err_set),
        .st_idle  (st_idle),
        .st_conn  (st_conn)
    );

    ic_idle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_req  (dis_req),
        .con_req  (con_req),
        .idle_ack (idle_ack),
        .idle_ind (idle_ind),
        .expire   (expire),
        .ack_lim  (CNT_W'(ack_lim)),
        .idle_lim (CNT_W'(idle_lim)),
        .hold_lim (CNT_W'(hold_lim)),
        .tmr_limit(tmr_limit),
        .restart  (restart),
        .err_set  (err_set),
        .idle_req (idle_req),
        .st_idle  (st_idle),
        .st_conn  (st_conn)
    );

    ic_idle_timer #(
        .TICK_DIV(TICK_DIV),
        .CNT_W   (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .limit  (tmr_limit),
        .expire (expire)
    );

endmodule

// File: tb/sim_ic_idle_ctrl.sv
`timescale 1ns/1ps
module sim_ic_idle_ctrl;
    localparam int DIV = 4;
    localparam logic [1:0] CTRL = 2'd0, TIME = 2'd1, STAT = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = CTRL;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        idle_ack = 1'b0;
    logic        idle_ind = 1'b0;
    logic        idle_req;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ic_idle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .idle_ack(idle_ack), .idle_ind(idle_ind), .idle_req(idle_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] tm(input int a, input int i, input int h);
        return 32'((h & 63) << 16 | (i & 31) << 8 | (a & 31));
    endfunction

    task automatic count_req(output int n);
        n = 0;
        while (idle_req && n < 2000) begin n++; @(negedge clk); end
    endtask

    initial begin
        #1200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 idle_req", 32'(idle_req), 0);
        rd(STAT, v); chk("R1 status", v, 32'h8);
        rd(TIME, v); chk("R1 timing", v, 32'h0008_1010);

        // R2 field placement
        wr(TIME, 32'hFFFF_FFFF); rd(TIME, v); chk("R2 all ones", v, 32'h003F_1F1F);
        wr(TIME, 32'hABCD_1234); rd(TIME, v);
        chk("R2 pattern", v, tm(32'h14, 32'h12, 32'h0D));

        // R3 mask bits
        wr(CTRL, 32'h0000_0004); repeat (3) @(negedge clk);
        chk("R3 no enable", 32'(idle_req), 0);
        wr(CTRL, 32'h0004_0000); repeat (3) @(negedge clk);
        chk("R3 enable only", 32'(idle_req), 0);
        wr(CTRL, 32'h0008_0004); repeat (3) @(negedge clk);
        chk("R3 wrong enable", 32'(idle_req), 0);
        wr(CTRL, 32'h0008_0008); rd(STAT, v);
        chk("R9 connect in Connected", v, 32'h8);

        // R5 acknowledge window sweep
        for (int a = 0; a < 32; a++) begin
            wr(TIME, tm(a, 31, 0));
            wr(CTRL, 32'h0004_0004);
            chk("R4 req raised", 32'(idle_req), 1);
            n = 0;
            while (idle_req && n < 2000) begin
                if (a == 7) begin reg_wr = 1'b1; reg_sel = CTRL; reg_wdata = 32'h0008_0008; end
                n++; @(negedge clk);
            end
            reg_wr = 1'b0;
            chk(a == 7 ? "R9 connect in Request" : "R5 ack window", n, (a + 1) * DIV);
            rd(STAT, v); chk("R5 error status", v, 32'h9);
            wr(CTRL, 32'h0000_0001); rd(STAT, v); chk("R10 unmasked clear", v, 32'h9);
            wr(CTRL, 32'h0001_0001); rd(STAT, v); chk("R10 masked clear", v, 32'h8);
        end

        // R5 acknowledge at the last cycle of the window and one cycle late
        foreach (v[k]) begin
            if (k < 4) begin
                automatic int a = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 31;
                wr(TIME, tm(a, 31, 0));
                wr(CTRL, 32'h0004_0004);
                repeat ((a + 1) * DIV - 1) @(negedge clk);
                idle_ack = 1'b1;
                @(negedge clk);
                chk("R5 last-cycle ack", 32'(idle_req), 1);
                rd(STAT, v); chk("R4 status waiting", v, 32'h0);
                idle_ind = 1'b1;
                @(negedge clk);
                rd(STAT, v); chk("R4 status idle", v, 32'h4);
                idle_ind = 1'b0;
                repeat (6) @(negedge clk);
                wr(CTRL, 32'h0008_0008);
                chk("R8 req dropped", 32'(idle_req), 0);
                rd(STAT, v); chk("R8 release status", v, 32'h0);
                idle_ack = 1'b0;
                @(negedge clk);
                rd(STAT, v); chk("R8 back connected", v, 32'h8);

                wr(CTRL, 32'h0004_0004);
                repeat ((a + 1) * DIV) @(negedge clk);
                idle_ack = 1'b1;
                chk("R5 late ack", 32'(idle_req), 0);
                rd(STAT, v); chk("R5 late ack status", v, 32'h9);
                idle_ack = 1'b0;
                wr(CTRL, 32'h0001_0001);
            end
        end

        // R6 idle window sweep
        for (int i = 0; i < 32; i++) begin
            wr(TIME, tm(31, i, 0));
            wr(CTRL, 32'h0004_0004);
            idle_ack = 1'b1;
            @(negedge clk);
            count_req(n);
            idle_ack = 1'b0;
            chk("R6 idle window", n, (i + 1) * DIV);
            rd(STAT, v); chk("R6 error status", v, 32'h9);
            wr(CTRL, 32'h0001_0001);
        end

        // R7 hold sweep with a connect written every cycle
        for (int h = 0; h < 64; h++) begin
            wr(TIME, tm(31, 31, h));
            wr(CTRL, 32'h0004_0004);
            idle_ack = 1'b1;
            @(negedge clk);
            idle_ind = 1'b1;
            reg_wr = 1'b1; reg_sel = CTRL; reg_wdata = 32'h0008_0008;
            @(negedge clk);
            count_req(n);
            reg_wr = 1'b0; idle_ind = 1'b0; idle_ack = 1'b0;
            chk("R7 hold length", n, (h + 1) * DIV + 1);
            @(negedge clk);
            rd(STAT, v); chk("R7 connected after", v, 32'h8);
        end

        // R9 disconnect in Idle is dropped; R8 release timeout
        wr(TIME, tm(3, 31, 0));
        wr(CTRL, 32'h0004_0004);
        idle_ack = 1'b1;
        @(negedge clk);
        idle_ind = 1'b1;
        @(negedge clk);
        idle_ind = 1'b0;
        repeat (6) @(negedge clk);
        wr(CTRL, 32'h0004_0004);
        rd(STAT, v); chk("R9 disconnect in Idle", v, 32'h4);
        chk("R9 req kept", 32'(idle_req), 1);
        wr(CTRL, 32'h0008_0008);
        n = 0;
        rd(STAT, v);
        while (v == 32'h0 && n < 2000) begin n++; @(negedge clk); rd(STAT, v); end
        chk("R8 release window", n, (3 + 1) * DIV);
        chk("R8 release timeout status", v, 32'h9);
        idle_ack = 1'b0;
        wr(CTRL, 32'h0001_0001);
        rd(STAT, v); chk("R10 final clear", v, 32'h8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule